// File: doc/BRIEF.md
# Freezable UART Transmitter

This block turns bytes into a serial NRZ line. Bytes enter through a valid/ready write port into a small transmit queue. A serializer takes them out one at a time and sends each as a frame. A frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. The line rests high between frames. When more bytes are queued, frames follow one another with no idle gap.

There are two timing modes. In asynchronous mode each bit lasts 8, 16 or 32 input clocks, chosen by a divider select. In synchronous (isochronous) mode each input clock carries exactly one bit. The mode and the divider are captured at the start of every frame, so changing them during a frame has no effect on that frame. An internal request-to-send output is high for as long as a frame is on the line.

A freeze input stops transmission cleanly. Every byte accepted before freeze rose is still sent in full, and then the line rests. While frozen, the queue keeps accepting writes up to its capacity. Releasing freeze resumes with the first unsent byte, so no byte is repeated or dropped. A length setting limits the queue to a single entry or lets it use its full depth. This setting bounds how many bytes a freeze has to drain.

Top module: `uart_tx_freeze`

## Requirements
- R1: Every frame is one 0 start bit, then the 8 data bits least significant bit first, then one stop bit at 1. The line is 1 whenever no frame is being sent.
- R2: In asynchronous mode (`sync_mode`=0) every bit of a frame lasts N clocks. N is 8 when `div_sel`=00, 16 when 01, 32 when 10, and 16 when 11.
- R3: In synchronous mode (`sync_mode`=1) every bit lasts exactly one clock.
- R4: If the queue holds a byte and sending is allowed when a stop bit ends, the next start bit begins in the very next clock, with no idle clock between.
- R5: Bytes are sent in the order they were accepted, each exactly once.
- R6: With `fifo_one`=0 the queue holds 8 bytes, and `wr_ready` is low while 8 are held.
- R7: With `fifo_one`=1 the queue holds 1 byte, and `wr_ready` is low while 1 is held.
- R8: After `freeze` rises, every byte accepted before the rise is sent completely.
- R9: Once those bytes are sent and while `freeze` stays high, `txd` stays 1 and `rts` stays 0. Writes are still accepted up to the queue's capacity, but none of them is sent.
- R10: After `freeze` falls, sending resumes with the oldest unsent byte.
- R11: `rts` is 1 during every clock of a frame, including the start and stop bits, and 0 while the line is idle.
- R12: `sync_mode` and `div_sel` are captured when a frame starts. Changing them during a frame does not alter that frame's bit timing.
- R13: After reset `txd` is 1, `rts` is 0 and `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one bit time per clock in synchronous mode |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request for a byte |
| wr_data | input | 8 | Byte to queue |
| wr_ready | output | 1 | Queue can accept a byte this clock |
| freeze | input | 1 | Drain already accepted bytes, then hold the line idle |
| fifo_one | input | 1 | 1 limits the queue to a single entry |
| sync_mode | input | 1 | 1 selects one bit per clock |
| div_sel | input | 2 | Clocks per bit in asynchronous mode |
| txd | output | 1 | Serial NRZ output |
| rts | output | 1 | Request-to-send, high while a frame is sent |

## Verification
Assertions check the following on every clock:
- each frame opens with a low start bit and closes with a high stop bit;
- the queue never underflows or overflows;
- the captured configuration holds steady mid-frame;
- each bit lasts one clock in synchronous mode;
- the freeze drain count never exceeds the queue contents;
- a frozen, drained transmitter stays idle.

Only the bench's scenarios can show some properties:
- that the data bits, their order and the exact bit durations are right across many frames;
- that a freeze drains exactly the bytes accepted before it;
- that bytes written while frozen are held and later sent in order;
- that the single-entry and full-depth capacities hold;
- that queued frames run back to back.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int TIMER_W = 6;

    typedef enum logic [1:0] {
        DIV8    = 2'b00,
        DIV16   = 2'b01,
        DIV32   = 2'b10,
        DIV_RSV = 2'b11
    } div_sel_e;

    // Clocks in one bit time for a given mode and divider choice
    function automatic logic [TIMER_W-1:0] bit_clocks(input logic sync, input div_sel_e sel);
        if (sync) begin
            return TIMER_W'(1);
        end
        case (sel)
            DIV8:    return TIMER_W'(8);
            DIV32:   return TIMER_W'(32);
            default: return TIMER_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_queue.sv
module uart_tx_queue #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic              push_ready_o,
    input  logic              one_entry_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic              empty_o,
    output logic [CNT_W-1:0]  count_o
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             count;
    } q_state_t;

    q_state_t q_d, q_q;
    logic [CNT_W-1:0] cap;
    logic push;

    always_comb begin
        q_d          = q_q;
        cap          = one_entry_i ? CNT_W'(1) : CNT_W'(DEPTH);
        push_ready_o = (q_q.count < cap);
        push         = push_valid_i && push_ready_o;
        if (push) begin
            q_d.mem[q_q.wr] = push_data_i;
            q_d.wr = (q_q.wr == PTR_W'(DEPTH - 1)) ? '0 : q_q.wr + PTR_W'(1);
        end
        if (pop_i) begin
            q_d.rd = (q_q.rd == PTR_W'(DEPTH - 1)) ? '0 : q_q.rd + PTR_W'(1);
        end
        q_d.count = q_q.count + CNT_W'(push) - CNT_W'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign head_o  = q_q.mem[q_q.rd];
    assign empty_o = (q_q.count == '0);
    assign count_o = q_q.count;

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (q_q.count != '0));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.count <= CNT_W'(DEPTH));

    assert_single_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (one_entry_i && $past(one_entry_i) && $past(q_q.count) <= CNT_W'(1))
            |-> (q_q.count <= CNT_W'(1)));

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             pop_i,
    output logic             allow_o
);

    typedef struct packed {
        logic             frz;
        logic [CNT_W-1:0] drain;
    } h_state_t;

    h_state_t h_d, h_q;
    logic rise;
    logic [CNT_W-1:0] base;

    always_comb begin
        h_d     = h_q;
        rise    = freeze_i && !h_q.frz;
        // on the rising clock the snapshot is the current queue content
        base    = rise ? count_i : h_q.drain;
        allow_o = !freeze_i || (base != '0);
        h_d.frz = freeze_i;
        h_d.drain = freeze_i ? (base - CNT_W'(pop_i)) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assert_drain_within_queue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        h_q.drain <= count_i);

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W   = 8,
    localparam int FRAME_W = DATA_W + 2,
    localparam int IDX_W   = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              allow_i,
    input  logic              empty_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              sync_i,
    input  logic [1:0]        div_i,
    output logic              pop_o,
    output logic              busy_o,
    output logic              txd_o
);

    typedef struct packed {
        logic               active;
        logic [FRAME_W-1:0] shreg;
        logic [IDX_W-1:0]   idx;
        logic [TIMER_W-1:0] timer;
        logic               sync;
        div_sel_e           div;
    } s_state_t;

    s_state_t s_d, s_q;
    logic bit_end, last_end, take;

    always_comb begin
        s_d      = s_q;
        bit_end  = s_q.active && (s_q.timer == '0);
        last_end = bit_end && (s_q.idx == IDX_W'(FRAME_W - 1));
        take     = allow_i && !empty_i && (!s_q.active || last_end);
        pop_o    = take;
        if (take) begin
            s_d.active = 1'b1;
            s_d.shreg  = {1'b1, data_i, 1'b0};
            s_d.idx    = '0;
            s_d.timer  = bit_clocks(sync_i, div_sel_e'(div_i)) - TIMER_W'(1);
            s_d.sync   = sync_i;
            s_d.div    = div_sel_e'(div_i);
        end else if (last_end) begin
            s_d.active = 1'b0;
        end else if (bit_end) begin
            s_d.shreg = {1'b1, s_q.shreg[FRAME_W-1:1]};
            s_d.idx   = s_q.idx + IDX_W'(1);
            s_d.timer = bit_clocks(s_q.sync, s_q.div) - TIMER_W'(1);
        end else if (s_q.active) begin
            s_d.timer = s_q.timer - TIMER_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.shreg  <= '1;
            s_q.div    <= DIV16;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = s_q.active;
    assign txd_o  = s_q.active ? s_q.shreg[0] : 1'b1;

    assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !txd_o);

    assert_stop_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        last_end |-> txd_o);

    assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !take) |=> ($stable(s_q.sync) && $stable(s_q.div)));

    assert_one_clock_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && s_q.sync) |-> (s_q.timer == '0));

endmodule

// File: rtl/uart_tx_freeze.sv
module uart_tx_freeze #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              freeze,
    input  logic              fifo_one,
    input  logic              sync_mode,
    input  logic [1:0]        div_sel,
    output logic              txd,
    output logic              rts
);

    logic              pop;
    logic              empty;
    logic              allow;
    logic [DATA_W-1:0] head;
    logic [CNT_W-1:0]  count;

    uart_tx_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_valid_i (wr_valid),
        .push_data_i  (wr_data),
        .push_ready_o (wr_ready),
        .one_entry_i  (fifo_one),
        .pop_i        (pop),
        .head_o       (head),
        .empty_o      (empty),
        .count_o      (count)
    );

    uart_tx_hold #(.DEPTH(DEPTH)) i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze_i (freeze),
        .count_i  (count),
        .pop_i    (pop),
        .allow_o  (allow)
    );

    uart_tx_serializer #(.DATA_W(DATA_W)) i_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .allow_i (allow),
        .empty_i (empty),
        .data_i  (head),
        .sync_i  (sync_mode),
        .div_i   (div_sel),
        .pop_o   (pop),
        .busy_o  (rts),
        .txd_o   (txd)
    );

    assert_frozen_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !allow && !rts) |=> !rts);

    assert_idle_line_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rts |-> txd);

endmodule

// File: tb/test_uart_tx_freeze.sv
module test_uart_tx_freeze;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_ready;
    logic       freeze = 1'b0;
    logic       fifo_one = 1'b0;
    logic       sync_mode = 1'b0;
    logic [1:0] div_sel = 2'b01;
    logic       txd;
    logic       rts;

    int checks = 0;
    int fails = 0;
    int frames_seen = 0;
    int pushed = 0;
    int gap_zero = 0;
    longint cyc = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_tx_freeze i_uart_tx_freeze (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .freeze(freeze), .fifo_one(fifo_one),
        .sync_mode(sync_mode), .div_sel(div_sel), .txd(txd), .rts(rts)
    );

    function automatic int blen(input logic s, input logic [1:0] d);
        if (s) return 1;
        if (d == 2'b00) return 8;
        if (d == 2'b10) return 32;
        return 16;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d, input int tries, output bit acc);
        acc = 1'b0;
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        for (int i = 0; i < tries && !acc; i++) begin
            if (wr_ready) begin
                @(posedge clk);
                exp_q.push_back(d);
                pushed++;
                acc = 1'b1;
                @(negedge clk);
            end else begin
                @(negedge clk);
            end
        end
        wr_valid = 1'b0;
    endtask

    task automatic wait_frames(input int target, input int limit);
        for (int i = 0; i < limit && frames_seen < target; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        wait_frames(pushed, 40000);
        for (int i = 0; i < 100 && rts; i++) @(negedge clk);
    endtask

    // Line monitor: decodes each frame against the expected byte stream
    initial begin
        longint prev_end = -10;
        wait (rst_n);
        forever begin
            @(posedge clk);
            #2;
            if (txd === 1'b0) begin
                int L;
                logic [7:0] e;
                logic [9:0] fr;
                bit ok;
                L  = blen(sync_mode, div_sel);
                ok = 1'b1;
                if (cyc - prev_end - 1 == 0) gap_zero++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected frame", 1, 0);
                    e = 8'h00;
                end else begin
                    e = exp_q.pop_front();
                end
                fr = {1'b1, e, 1'b0};
                for (int b = 0; b < 10; b++) begin
                    for (int c = 0; c < L; c++) begin
                        if (!(b == 0 && c == 0)) begin
                            @(posedge clk);
                            #2;
                        end
                        if (txd !== fr[b] || rts !== 1'b1) ok = 1'b0;
                    end
                end
                chk(ok, "R1 R2 R3 R11 frame shape", ok, 1);
                prev_end = cyc;
                frames_seen++;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog all requirements", 0, 1);
        summary();
        $finish;
    end

    initial begin
        bit acc;
        int base;
        int n_acc;
        int z0;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R13 txd", txd, 1);
        chk(rts == 1'b0, "R13 rts", rts, 0);
        chk(wr_ready == 1'b1, "R13 ready", wr_ready, 1);

        // R12: divider change mid-frame leaves the running frame untouched
        sync_mode = 1'b0; div_sel = 2'b01;
        wr(8'h5A, 100, acc);
        repeat (40) @(negedge clk);
        div_sel = 2'b00;
        wr(8'hC3, 100, acc);
        wait_idle();
        chk(frames_seen == 2, "R12 frames", frames_seen, 2);
        chk(rts == 1'b0, "R11 idle rts", rts, 0);

        // R6 R8 R9 R10 with full-depth queue, synchronous mode
        sync_mode = 1'b1; fifo_one = 1'b0;
        base = frames_seen;
        for (int k = 0; k < 6; k++) wr(8'h30 + 8'(k), 100, acc);
        @(negedge clk);
        freeze = 1'b1;
        wait_frames(base + 6, 2000);
        chk(frames_seen == base + 6, "R8 drained", frames_seen, base + 6);
        repeat (100) @(negedge clk);
        chk(frames_seen == base + 6, "R9 no frame", frames_seen, base + 6);
        chk(txd == 1'b1 && rts == 1'b0, "R9 line idle", {txd, rts}, 2);
        n_acc = 0;
        for (int k = 0; k < 8; k++) begin
            wr(8'hA0 + 8'(k), 5, acc);
            if (acc) n_acc++;
        end
        chk(n_acc == 8, "R6 R9 accepted while frozen", n_acc, 8);
        chk(wr_ready == 1'b0, "R6 ready when full", wr_ready, 0);
        wr(8'hFF, 5, acc);
        chk(!acc, "R6 write refused", acc, 0);
        repeat (50) @(negedge clk);
        chk(frames_seen == base + 6, "R9 held", frames_seen, base + 6);
        freeze = 1'b0;
        wait_frames(base + 14, 2000);
        chk(frames_seen == base + 14, "R10 resumed", frames_seen, base + 14);
        wait_idle();

        // R7 R8 R10 with single-entry queue, asynchronous divide by 8
        sync_mode = 1'b0; div_sel = 2'b00; fifo_one = 1'b1;
        base = frames_seen;
        for (int k = 0; k < 3; k++) wr(8'h61 + 8'(k), 5000, acc);
        @(negedge clk);
        freeze = 1'b1;
        wait_frames(base + 3, 3000);
        chk(frames_seen == base + 3, "R8 single drained", frames_seen, base + 3);
        wr(8'h7E, 5, acc);
        chk(acc, "R7 one accepted", acc, 1);
        chk(wr_ready == 1'b0, "R7 ready low at one", wr_ready, 0);
        wr(8'h7F, 5, acc);
        chk(!acc, "R7 second refused", acc, 0);
        repeat (100) @(negedge clk);
        chk(frames_seen == base + 3, "R9 single held", frames_seen, base + 3);
        freeze = 1'b0;
        wait_frames(base + 4, 1000);
        chk(frames_seen == base + 4, "R10 single resumed", frames_seen, base + 4);
        wait_idle();

        // R4: queued frames run back to back after release
        fifo_one = 1'b0; sync_mode = 1'b1;
        @(negedge clk);
        freeze = 1'b1;
        base = frames_seen;
        for (int k = 0; k < 3; k++) wr(8'h11 * 8'(k + 1), 100, acc);
        repeat (30) @(negedge clk);
        chk(frames_seen == base, "R9 nothing drained", frames_seen, base);
        z0 = gap_zero;
        freeze = 1'b0;
        wait_frames(base + 3, 500);
        chk(gap_zero - z0 >= 2, "R4 no gap", gap_zero - z0, 2);
        wait_idle();

        // Random bursts across modes, dividers and queue lengths
        for (int it = 0; it < 30; it++) begin
            int n;
            wait_idle();
            @(negedge clk);
            sync_mode = ($urandom % 4) == 0;
            div_sel   = 2'($urandom % 4);
            fifo_one  = ($urandom % 3) == 0;
            n = 1 + ($urandom % 6);
            for (int k = 0; k < n; k++) wr(8'($urandom), 20000, acc);
            wait_frames(pushed, 20000);
            chk(frames_seen == pushed, "R5 R2 burst", frames_seen, pushed);
        end
        wait_idle();
        repeat (5) @(negedge clk);
        chk(rts == 1'b0 && txd == 1'b1, "R11 final idle", {rts, txd}, 1);
        chk(exp_q.size() == 0, "R5 all sent", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule